// File: doc/BRIEF.md
# Programmable LCD Raster Timing Generator

This block produces the scan timing for an active-matrix display panel. A divider derived from the block clock sets the pixel rate. Two nested phase counters, one horizontal and one vertical, step through the sync pulse, the leading wait, the visible region and the trailing wait. From those counters the block drives horizontal and vertical sync, a data-enable strobe, the pixel clock pin, and the coordinates of the visible pixel being scanned. Each output has its own polarity select.

The configuration fields use two encodings. All horizontal lengths and both sync widths are stored as the count minus one. The vertical leading and trailing waits are stored as literal line counts, so a zero removes that phase altogether. Three sticky status bits (frame start, frame end, stop complete) are cleared by writing ones. Each bit drives the interrupt line unless its mask bit is set. When the enable is dropped, the current frame is allowed to finish before the block halts.

Top module: `lcd_raster_timer`

## Requirements
- R1: `pclkEn` is high for one block clock out of every 2*(`cfgDiv`+1). In that cycle, `pclk` is at its high half when `invPclk` is 0, and at its low half when `invPclk` is 1.
- R2: Each line is made of `cfgHsyncW`+1 sync pixels, then `cfgHleadW`+1 leading pixels, then `cfgActW`+1 visible pixels, then `cfgHtrailW`+1 trailing pixels, in that order. Lengths are counted in `pclkEn` periods.
- R3: Each frame is made of `cfgVsyncW`+1 sync lines, then `cfgVleadN` leading lines, then `cfgActH`+1 visible lines, then `cfgVtrailN` trailing lines, in that order. A zero in either literal wait field means that phase has no lines.
- R4: Data-enable is active only on visible pixels of visible lines. During those pixels, `pixX` and `pixY` count from 0 along the line and down the frame. At all other times both are 0.
- R5: Setting `invHsync`, `invVsync` or `invDe` to 1 makes the matching output active low. The same inversion applies to its inactive (idle) level.
- R6: Status bit 0 (frame start) is set when a frame begins, whether from idle or on wrap-around. Status bit 1 (frame end) is set when the last line of a frame completes. Both bits stay set until they are cleared.
- R7: A cycle with `stClrWr` high clears every status bit whose position in `stClrBits` is 1. It leaves the other bits unchanged.
- R8: `irq` is high exactly when some status bit is 1 and the `irqMask` bit at the same position is 0.
- R9: If `enable` goes low during a frame, the block completes that frame and then halts. When it halts, it sets status bit 2 (stop complete) and returns all sync and enable outputs to their inactive levels.
- R10: After reset, `status` is 0 and `irq` is low. The sync and enable outputs sit at their inactive levels until `enable` is seen high on a `pclkEn` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; sampled on pixel ticks |
| cfgDiv | input | 8 | Pixel clock divisor |
| cfgActW | input | 10 | Visible pixels per line minus one |
| cfgHsyncW | input | 6 | Horizontal sync width minus one |
| cfgHleadW | input | 8 | Leading line wait minus one |
| cfgHtrailW | input | 8 | Trailing line wait minus one |
| cfgActH | input | 10 | Visible lines minus one |
| cfgVsyncW | input | 6 | Vertical sync lines minus one |
| cfgVleadN | input | 8 | Leading frame wait, literal lines |
| cfgVtrailN | input | 8 | Trailing frame wait, literal lines |
| invVsync | input | 1 | Vertical sync active low |
| invHsync | input | 1 | Horizontal sync active low |
| invPclk | input | 1 | Pixel clock inverted |
| invDe | input | 1 | Data-enable active low |
| irqMask | input | 3 | Per-status interrupt mask |
| stClrWr | input | 1 | Status clear strobe |
| stClrBits | input | 3 | Write-one-to-clear pattern |
| pclk | output | 1 | Pixel clock pin |
| pclkEn | output | 1 | One-cycle pixel tick |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pixX | output | 10 | Visible column |
| pixY | output | 10 | Visible row |
| status | output | 3 | {stop complete, frame end, frame start} |
| irq | output | 1 | Unmasked status present |

## Verification
The assertions assume that the configuration fields are held steady while the block is running. They also assume the waits are never negative, so the counters stay inside the bounds those fields set. The stimulus changes configuration only while the block is idle. It raises and lowers `enable` just after a pixel tick, so that every frame it starts or stops is aligned to a known tick. That gives each frame a predictable pixel-by-pixel sequence, which a software model can list in advance.

// File: rtl/lcd_raster_pkg.sv
package lcd_raster_pkg;
  // four phases used by both the line and the frame sequencers
  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_LEAD  = 2'd1,
    PH_SHOW  = 2'd2,
    PH_TRAIL = 2'd3
  } phase_e;

  // control -> datapath strobes
  typedef struct packed {
    logic tick;   // pixel period boundary
    logic run;    // scanning active
  } strobe_t;
endpackage

// File: rtl/lcd_raster_ctrl.sv
module lcd_raster_ctrl
  import lcd_raster_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int ST_W  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [DIV_W-1:0] cfgDiv,
  input  logic             invPclk,
  input  logic [ST_W-1:0]  irqMask,
  input  logic             stClrWr,
  input  logic [ST_W-1:0]  stClrBits,
  input  logic             frameLast,
  output strobe_t          strb,
  output logic             pclk,
  output logic             pclkEn,
  output logic [ST_W-1:0]  status,
  output logic             irq
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] divCnt;
  logic [CNT_W-1:0] divTerm;
  logic             tick;
  logic             running;
  logic             sofSet, eofSet, doneSet;
  logic [ST_W-1:0]  stat, setVec, clrVec;

  // divider: one tick every 2*(div+1) clocks
  assign divTerm = {cfgDiv, 1'b1};
  assign tick    = (divCnt >= divTerm);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     divCnt <= '0;
    else if (tick) divCnt <= '0;
    else           divCnt <= divCnt + CNT_W'(1);
  end

  // second half of the period is the high half of the raw clock
  assign pclk   = (divCnt > {1'b0, cfgDiv}) ^ invPclk;
  assign pclkEn = tick;

  // run / stop sequencing
  assign sofSet  = tick && enable && (!running || frameLast);
  assign eofSet  = tick && running && frameLast;
  assign doneSet = tick && running && frameLast && !enable;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) running <= 1'b0;
    else if (tick) begin
      if (!running && enable)                 running <= 1'b1;
      else if (running && frameLast && !enable) running <= 1'b0;
    end
  end

  assign strb.tick = tick;
  assign strb.run  = running;

  // sticky status, write one to clear, set wins
  assign setVec = {doneSet, eofSet, sofSet};
  assign clrVec = stClrWr ? stClrBits : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stat <= '0;
    else       stat <= (stat & ~clrVec) | setVec;
  end

  assign status = stat;
  assign irq    = |(stat & ~irqMask);

  // R1: ticks never come back to back
  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);

  // R9: scanning only stops at a frame boundary with enable low
  p_stop_at_frame_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(running) |-> $past(frameLast && !enable && tick));

  // R6: a frame-start event leaves its status bit set
  p_sof_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    sofSet |=> stat[0]);

  // R7: a clear with no coincident set removes the bit
  p_clear_eof_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stClrWr && stClrBits[1] && !eofSet) |=> !stat[1]);
endmodule

// File: rtl/lcd_raster_dp.sv
module lcd_raster_dp
  import lcd_raster_pkg::*;
#(
  parameter int ACT_W   = 10,
  parameter int SYNC_W  = 6,
  parameter int PORCH_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [ACT_W-1:0]   cfgActW,
  input  logic [SYNC_W-1:0]  cfgHsyncW,
  input  logic [PORCH_W-1:0] cfgHleadW,
  input  logic [PORCH_W-1:0] cfgHtrailW,
  input  logic [ACT_W-1:0]   cfgActH,
  input  logic [SYNC_W-1:0]  cfgVsyncW,
  input  logic [PORCH_W-1:0] cfgVleadN,
  input  logic [PORCH_W-1:0] cfgVtrailN,
  input  logic               invHsync,
  input  logic               invVsync,
  input  logic               invDe,
  output logic               hsync,
  output logic               vsync,
  output logic               de,
  output logic [ACT_W-1:0]   pixX,
  output logic [ACT_W-1:0]   pixY,
  output logic               frameLast
);
  localparam int MAX_A = (ACT_W > PORCH_W) ? ACT_W : PORCH_W;
  localparam int CNT_W = (MAX_A > SYNC_W) ? MAX_A : SYNC_W;

  phase_e           hPh, vPh;
  logic [CNT_W-1:0] hCnt, vCnt;
  logic             hLast, vLast, lineEnd;
  logic             hsyncAct, vsyncAct, deAct;

  function automatic phase_e hNext(input phase_e p);
    case (p)
      PH_SYNC: hNext = PH_LEAD;
      PH_LEAD: hNext = PH_SHOW;
      PH_SHOW: hNext = PH_TRAIL;
      default: hNext = PH_SYNC;
    endcase
  endfunction

  // literal vertical waits may be zero: skip the phase
  function automatic phase_e vNext(input phase_e p, input logic leadZero,
                                   input logic trailZero);
    case (p)
      PH_SYNC: vNext = leadZero  ? PH_SHOW : PH_LEAD;
      PH_LEAD: vNext = PH_SHOW;
      PH_SHOW: vNext = trailZero ? PH_SYNC : PH_TRAIL;
      default: vNext = PH_SYNC;
    endcase
  endfunction

  always_comb begin
    case (hPh)
      PH_SYNC: hLast = (hCnt == CNT_W'(cfgHsyncW));
      PH_LEAD: hLast = (hCnt == CNT_W'(cfgHleadW));
      PH_SHOW: hLast = (hCnt == CNT_W'(cfgActW));
      default: hLast = (hCnt == CNT_W'(cfgHtrailW));
    endcase
  end

  always_comb begin
    case (vPh)
      PH_SYNC: vLast = (vCnt == CNT_W'(cfgVsyncW));
      PH_LEAD: vLast = (vCnt == CNT_W'(cfgVleadN) - CNT_W'(1));
      PH_SHOW: vLast = (vCnt == CNT_W'(cfgActH));
      default: vLast = (vCnt == CNT_W'(cfgVtrailN) - CNT_W'(1));
    endcase
  end

  assign lineEnd   = (hPh == PH_TRAIL) && hLast;
  assign frameLast = strb.run && lineEnd && vLast &&
                     ((vPh == PH_TRAIL) ||
                      ((vPh == PH_SHOW) && (cfgVtrailN == '0)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hPh <= PH_SYNC; hCnt <= '0;
      vPh <= PH_SYNC; vCnt <= '0;
    end else if (!strb.run) begin
      hPh <= PH_SYNC; hCnt <= '0;
      vPh <= PH_SYNC; vCnt <= '0;
    end else if (strb.tick) begin
      if (hLast) begin
        hCnt <= '0;
        hPh  <= hNext(hPh);
        if (hPh == PH_TRAIL) begin
          if (vLast) begin
            vCnt <= '0;
            vPh  <= vNext(vPh, cfgVleadN == '0, cfgVtrailN == '0);
          end else begin
            vCnt <= vCnt + CNT_W'(1);
          end
        end
      end else begin
        hCnt <= hCnt + CNT_W'(1);
      end
    end
  end

  assign hsyncAct = strb.run && (hPh == PH_SYNC);
  assign vsyncAct = strb.run && (vPh == PH_SYNC);
  assign deAct    = strb.run && (hPh == PH_SHOW) && (vPh == PH_SHOW);

  assign hsync = hsyncAct ^ invHsync;
  assign vsync = vsyncAct ^ invVsync;
  assign de    = deAct ^ invDe;
  assign pixX  = deAct ? hCnt[ACT_W-1:0] : '0;
  assign pixY  = deAct ? vCnt[ACT_W-1:0] : '0;

  // R4: visible column stays inside the programmed width
  p_x_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    deAct |-> (pixX <= cfgActW));

  // R3: vertical sync changes only on a pixel tick while running
  p_vsync_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !strb.tick) |=> $stable(vsyncAct));

  // R2: horizontal counter stays inside its phase length
  p_hsync_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    (hPh == PH_SYNC) |-> (hCnt <= CNT_W'(cfgHsyncW)));
endmodule

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer
  import lcd_raster_pkg::*;
#(
  parameter int ACT_W   = 10,
  parameter int SYNC_W  = 6,
  parameter int PORCH_W = 8,
  parameter int DIV_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [DIV_W-1:0]   cfgDiv,
  input  logic [ACT_W-1:0]   cfgActW,
  input  logic [SYNC_W-1:0]  cfgHsyncW,
  input  logic [PORCH_W-1:0] cfgHleadW,
  input  logic [PORCH_W-1:0] cfgHtrailW,
  input  logic [ACT_W-1:0]   cfgActH,
  input  logic [SYNC_W-1:0]  cfgVsyncW,
  input  logic [PORCH_W-1:0] cfgVleadN,
  input  logic [PORCH_W-1:0] cfgVtrailN,
  input  logic               invVsync,
  input  logic               invHsync,
  input  logic               invPclk,
  input  logic               invDe,
  input  logic [2:0]         irqMask,
  input  logic               stClrWr,
  input  logic [2:0]         stClrBits,
  output logic               pclk,
  output logic               pclkEn,
  output logic               hsync,
  output logic               vsync,
  output logic               de,
  output logic [ACT_W-1:0]   pixX,
  output logic [ACT_W-1:0]   pixY,
  output logic [2:0]         status,
  output logic               irq
);
  localparam int ST_W = 3;

  strobe_t strb;
  logic    frameLast;

  lcd_raster_ctrl #(.DIV_W(DIV_W), .ST_W(ST_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgDiv(cfgDiv),
    .invPclk(invPclk), .irqMask(irqMask), .stClrWr(stClrWr),
    .stClrBits(stClrBits), .frameLast(frameLast), .strb(strb),
    .pclk(pclk), .pclkEn(pclkEn), .status(status), .irq(irq)
  );

  lcd_raster_dp #(.ACT_W(ACT_W), .SYNC_W(SYNC_W), .PORCH_W(PORCH_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cfgActW(cfgActW), .cfgHsyncW(cfgHsyncW), .cfgHleadW(cfgHleadW),
    .cfgHtrailW(cfgHtrailW), .cfgActH(cfgActH), .cfgVsyncW(cfgVsyncW),
    .cfgVleadN(cfgVleadN), .cfgVtrailN(cfgVtrailN),
    .invHsync(invHsync), .invVsync(invVsync), .invDe(invDe),
    .hsync(hsync), .vsync(vsync), .de(de), .pixX(pixX), .pixY(pixY),
    .frameLast(frameLast)
  );
endmodule

// File: tb/lcd_raster_timer_tb_top.sv
module lcd_raster_timer_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [7:0] cfgDiv = 8'd0;
  logic [9:0] cfgActW = 10'd3, cfgActH = 10'd2;
  logic [5:0] cfgHsyncW = 6'd1, cfgVsyncW = 6'd0;
  logic [7:0] cfgHleadW = 8'd0, cfgHtrailW = 8'd1;
  logic [7:0] cfgVleadN = 8'd2, cfgVtrailN = 8'd1;
  logic invVsync = 0, invHsync = 0, invPclk = 0, invDe = 0;
  logic [2:0] irqMask = 3'b000;
  logic stClrWr = 0;
  logic [2:0] stClrBits = 3'b000;
  logic pclk, pclkEn, hsync, vsync, de, irq;
  logic [9:0] pixX, pixY;
  logic [2:0] status;

  always #5 clk = ~clk;

  lcd_raster_timer dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgDiv(cfgDiv),
    .cfgActW(cfgActW), .cfgHsyncW(cfgHsyncW), .cfgHleadW(cfgHleadW),
    .cfgHtrailW(cfgHtrailW), .cfgActH(cfgActH), .cfgVsyncW(cfgVsyncW),
    .cfgVleadN(cfgVleadN), .cfgVtrailN(cfgVtrailN), .invVsync(invVsync),
    .invHsync(invHsync), .invPclk(invPclk), .invDe(invDe),
    .irqMask(irqMask), .stClrWr(stClrWr), .stClrBits(stClrBits),
    .pclk(pclk), .pclkEn(pclkEn), .hsync(hsync), .vsync(vsync), .de(de),
    .pixX(pixX), .pixY(pixY), .status(status), .irq(irq)
  );

  typedef struct packed {
    logic hs; logic vs; logic de; logic [9:0] x; logic [9:0] y;
  } exp_t;

  exp_t q[$];
  int   nVec = 0;
  int   nFail = 0;
  bit   armed = 0;

  task automatic chk(input string req, input int act, input int exp);
    nVec++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // model of one frame, built from the phase lengths in the requirements
  task automatic push_frame();
    int vLen[4];
    int hLen[4];
    vLen[0] = cfgVsyncW + 1; vLen[1] = cfgVleadN;
    vLen[2] = cfgActH + 1;   vLen[3] = cfgVtrailN;
    hLen[0] = cfgHsyncW + 1; hLen[1] = cfgHleadW + 1;
    hLen[2] = cfgActW + 1;   hLen[3] = cfgHtrailW + 1;
    for (int vp = 0; vp < 4; vp++)
      for (int l = 0; l < vLen[vp]; l++)
        for (int hp = 0; hp < 4; hp++)
          for (int p = 0; p < hLen[hp]; p++) begin
            exp_t e;
            logic vis;
            vis  = (hp == 2) && (vp == 2);
            e.hs = (hp == 0) ^ invHsync;
            e.vs = (vp == 0) ^ invVsync;
            e.de = vis ^ invDe;
            e.x  = vis ? 10'(p) : 10'd0;
            e.y  = vis ? 10'(l) : 10'd0;
            q.push_back(e);
          end
  endtask

  // monitor: one expected item per pixel period (R2 R3 R4 R5)
  always @(negedge clk) begin
    if (armed && pclkEn) begin
      if (q.size() == 0) begin
        nFail++;
        $display("FAIL R2: pixel produced with empty queue, actual 1 expected 0");
      end else begin
        exp_t e, a;
        e = q.pop_front();
        a = '{hs: hsync, vs: vsync, de: de, x: pixX, y: pixY};
        nVec++;
        if (a != e) begin
          nFail++;
          $display("FAIL R2 R3 R4 R5: actual %h expected %h", a, e);
        end
        if (q.size() == 0) armed = 0;
      end
    end
  end

  task automatic wait_tick();
    do @(negedge clk); while (!pclkEn);
  endtask

  task automatic start_scan();
    wait_tick();
    #1;
    enable = 1'b1;
    armed  = 1'b1;
  endtask

  task automatic clear_st(input logic [2:0] bits);
    @(negedge clk);
    stClrWr = 1'b1; stClrBits = bits;
    @(negedge clk);
    stClrWr = 1'b0; stClrBits = 3'b000;
  endtask

  task automatic check_period(input int div);
    int n;
    wait_tick();
    n = 0;
    do begin @(negedge clk); n++; end while (!pclkEn);
    chk("R1 period", n, 2 * (div + 1));
    chk("R1 pclk level", int'(pclk), int'(!invPclk));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 status", int'(status), 0);
    chk("R10 irq", int'(irq), 0);
    chk("R10 hsync", int'(hsync), 0);
    chk("R10 vsync", int'(vsync), 0);
    chk("R10 de", int'(de), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 idle hsync after reset", int'(hsync), 0);

    // R1: divisor 0
    check_period(0);

    // config A: two frames, stop during the second
    push_frame();
    push_frame();
    start_scan();
    repeat (6) @(negedge clk);
    chk("R6 start set mid frame", int'(status), 3'b001);
    while (q.size() >= 40) @(negedge clk);
    enable = 1'b0;
    while (armed) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R9 all status after stop", int'(status), 3'b111);
    chk("R9 vsync idle", int'(vsync), 0);
    chk("R9 de idle", int'(de), 0);
    chk("R8 irq unmasked", int'(irq), 1);

    // R7 / R8: clear and masking
    clear_st(3'b001);
    chk("R7 clear start only", int'(status), 3'b110);
    irqMask = 3'b110;
    #1;
    chk("R8 masked irq", int'(irq), 0);
    irqMask = 3'b011;
    #1;
    chk("R8 done unmasked", int'(irq), 1);
    clear_st(3'b111);
    chk("R7 clear all", int'(status), 0);
    chk("R8 irq after clear", int'(irq), 0);

    // config B: inverted polarities, zero vertical waits, divisor 2
    cfgDiv = 8'd2; invPclk = 1; invHsync = 1; invVsync = 1; invDe = 1;
    cfgActW = 10'd4; cfgHsyncW = 6'd2; cfgHleadW = 8'd1; cfgHtrailW = 8'd0;
    cfgActH = 10'd1; cfgVsyncW = 6'd1; cfgVleadN = 8'd0; cfgVtrailN = 8'd0;
    irqMask = 3'b000;
    repeat (2) @(negedge clk);
    chk("R5 idle hsync inverted", int'(hsync), 1);
    chk("R5 idle vsync inverted", int'(vsync), 1);
    chk("R5 idle de inverted", int'(de), 1);
    check_period(2);
    push_frame();
    start_scan();
    repeat (3) @(negedge clk);
    enable = 1'b0;
    while (armed) @(negedge clk);
    repeat (8) @(negedge clk);
    chk("R3 R6 R9 status after single frame", int'(status), 3'b111);
    chk("R9 hsync idle inverted", int'(hsync), 1);
    chk("R4 x idle", int'(pixX), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end
endmodule